// File: doc/BRIEF.md
# Hypervisor Trap and Shadow-Context Controller

This controller sits next to a small 8-bit CPU core. It gives the core a fast, register-triggered way to enter a privileged hypervisor mode and to leave it again. The core's bus writes are decoded against a 64-register I/O window. When the core is in user mode, a write to any register in that window is a trap. In one clock the controller copies the caller's full context into shadow registers, switches to hypervisor mode and applies the fixed hypervisor memory configuration. It also loads the program counter with an entry vector that depends on which register was written. The value written is ignored.

While in hypervisor mode, the low window registers are ordinary write ports into the shadow copies. Hypervisor code can use them to prepare return values, for example setting the carry flag to report success. A write to the last register of the window leaves hypervisor mode. The whole shadow context is handed back to the core in one clock. An optional assist presents X doubled (with its top bit cleared) on entry, so that X can be used directly as an even jump-table index, while the original X is kept in the shadow copy.

The controller is a four-state machine. The states are USER, ENTER, HYPER and EXIT, with these transitions:
- TRAP: USER to ENTER, on a window write.
- ENTER to HYPER: always.
- LEAVE: HYPER to EXIT, on a write to the exit register.
- EXIT to USER: always.

In ENTER and EXIT, `ctx_load` and `pc_load` tell the core to take the presented context.

Top module: `hvt_ctrl`

## Requirements
- R1: After reset, `hv_mode`, `ctx_load` and `pc_load` are 0.
- R2: The window is $D640–$D67F; offset = address − $D640. In user mode a write to any offset raises a trap: on the next cycle `ctx_load` and `pc_load` are 1 and `hv_mode` is 1. The written data has no effect. Writes outside the window have no effect.
- R3: On entry, `pc_out` is $8000 + 4 × offset.
- R4: On entry, `a_out`, `y_out`, `z_out`, `flags_out` and `sp_out` equal the values presented on the matching inputs in the trap-write cycle.
- R5: With the assist enabled (default), `x_out` on entry is {0, x[5:0], 0}, where x is the X input in the trap-write cycle.
- R6: On entry, `cfg_out` is the hypervisor configuration $F0.
- R7: In hypervisor mode, a write to offset 63 leaves the hypervisor. On the next cycle `ctx_load` and `pc_load` are 1, `hv_mode` is 0, and every output carries the shadow context, including the original X and PC.
- R8: In hypervisor mode, writes to these offsets replace the shadow value returned at exit: 0 A, 1 X, 2 Y, 3 Z, 4 flags (bit 0 = carry), 5 SP, 6 PC low byte, 7 PC high byte, 8 memory configuration.
- R9: In hypervisor mode, writes to offsets 9–62 or outside the window cause no trap and no load, and leave the shadow context unchanged.
- R10: Writes made in a cycle where `ctx_load` is 1 (the ENTER or EXIT cycle) are ignored.
- R11: `ctx_load` is a single-cycle pulse, and `pc_load` equals it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | CPU write strobe |
| bus_addr | input | 16 | CPU write address |
| bus_wdata | input | 8 | CPU write data |
| pc_in | input | 16 | Caller return PC |
| a_in | input | 8 | Caller A |
| x_in | input | 8 | Caller X |
| y_in | input | 8 | Caller Y |
| z_in | input | 8 | Caller Z |
| flags_in | input | 8 | Caller flags |
| sp_in | input | 8 | Caller stack pointer |
| cfg_in | input | 8 | Caller memory configuration |
| hv_mode | output | 1 | Hypervisor mode status |
| ctx_load | output | 1 | Core loads A, X, Y, Z, flags, SP, configuration |
| pc_load | output | 1 | Core loads PC |
| pc_out | output | 16 | PC to load |
| a_out | output | 8 | A to load |
| x_out | output | 8 | X to load |
| y_out | output | 8 | Y to load |
| z_out | output | 8 | Z to load |
| flags_out | output | 8 | Flags to load |
| sp_out | output | 8 | Stack pointer to load |
| cfg_out | output | 8 | Memory configuration to load |

## Verification
A bus write can arrive in the same cycle as a context load. The core may still be driving a write while the controller presents the entry or exit context. The bench provokes this in two ways. It holds the strobe on with the exit address into the ENTER cycle. It also holds it on with a trap address into the EXIT cycle. The write is judged ignored if the following cycle shows no further load and `hv_mode` unchanged from the state just reached. A sweep over all 64 trap offsets, with shadow edits and ignored writes interleaved, checks each vector and each returned context arithmetically.

// File: rtl/hvt_pkg.sv
package hvt_pkg;
    localparam int DW = 8;
    localparam int AW = 16;

    // Shadow byte slots; slot index is also the hypervisor write offset
    localparam int SH_A     = 0;
    localparam int SH_X     = 1;
    localparam int SH_Y     = 2;
    localparam int SH_Z     = 3;
    localparam int SH_FLAGS = 4;
    localparam int SH_SP    = 5;
    localparam int SH_PCL   = 6;
    localparam int SH_PCH   = 7;
    localparam int SH_CFG   = 8;
    localparam int SH_COUNT = 9;

    typedef enum logic [1:0] {
        ST_USER  = 2'd0,
        ST_ENTER = 2'd1,
        ST_HYPER = 2'd2,
        ST_EXIT  = 2'd3
    } hv_state_e;

    typedef logic [SH_COUNT-1:0][DW-1:0] ctx_bytes_t;
endpackage

// File: rtl/hvt_decode.sv
module hvt_decode
    import hvt_pkg::*;
#(
    parameter logic [AW-1:0] WIN_BASE = 16'hD640,
    parameter int            WIN_REGS = 64,
    localparam int           OFF_W    = $clog2(WIN_REGS)
) (
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    output logic             win_hit,
    output logic             exit_hit,
    output logic [OFF_W-1:0] win_off
);
    logic [AW-1:0] rel;

    always_comb begin
        rel      = bus_addr - WIN_BASE;
        win_hit  = bus_we && (rel < AW'(WIN_REGS));
        win_off  = rel[OFF_W-1:0];
        exit_hit = win_hit && (win_off == OFF_W'(WIN_REGS - 1));
    end
endmodule

// File: rtl/hvt_fsm.sv
module hvt_fsm
    import hvt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_hit,
    input  logic exit_hit,
    output logic cap_en,
    output logic sh_we,
    output logic entry_sel,
    output logic ctx_load,
    output logic hv_mode
);
    hv_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_USER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_USER:  if (win_hit)  state_d = ST_ENTER;
            ST_ENTER:               state_d = ST_HYPER;
            ST_HYPER: if (exit_hit) state_d = ST_EXIT;
            ST_EXIT:                state_d = ST_USER;
            default:                state_d = ST_USER;
        endcase
    end

    always_comb begin
        cap_en    = 1'b0;
        sh_we     = 1'b0;
        entry_sel = 1'b0;
        ctx_load  = 1'b0;
        hv_mode   = 1'b0;
        unique case (state_q)
            ST_USER:  cap_en = win_hit;
            ST_ENTER: begin
                entry_sel = 1'b1;
                ctx_load  = 1'b1;
                hv_mode   = 1'b1;
            end
            ST_HYPER: begin
                hv_mode = 1'b1;
                sh_we   = win_hit && !exit_hit;
            end
            ST_EXIT:  ctx_load = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/hvt_shadow.sv
module hvt_shadow
    import hvt_pkg::*;
#(
    parameter int N     = SH_COUNT,
    parameter int SEL_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en,
    input  logic [N-1:0][DW-1:0]     cap_bytes,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [DW-1:0]            wr_data,
    output logic [N-1:0][DW-1:0]     sh_bytes
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sh_bytes[i] <= '0;
            else if (cap_en)
                sh_bytes[i] <= cap_bytes[i];
            else if (wr_en && (wr_sel == SEL_W'(i)))
                sh_bytes[i] <= wr_data;
        end
    end
endmodule

// File: rtl/hvt_ctrl.sv
module hvt_ctrl
    import hvt_pkg::*;
#(
    parameter logic [AW-1:0] WIN_BASE   = 16'hD640,
    parameter int            WIN_REGS   = 64,
    parameter logic [AW-1:0] VEC_BASE   = 16'h8000,
    parameter int            VEC_STRIDE = 4,
    parameter logic [DW-1:0] HV_CFG     = 8'hF0,
    parameter bit            X_DOUBLE   = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] z_in,
    input  logic [DW-1:0] flags_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] cfg_in,
    output logic          hv_mode,
    output logic          ctx_load,
    output logic          pc_load,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] x_out,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] z_out,
    output logic [DW-1:0] flags_out,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] cfg_out
);
    localparam int OFF_W = $clog2(WIN_REGS);

    logic             win_hit, exit_hit;
    logic [OFF_W-1:0] win_off;
    logic             cap_en, sh_we, entry_sel;
    ctx_bytes_t       cap_bytes, sh_bytes;
    logic [AW-1:0]    vec_q;
    logic [DW-1:0]    x_entry;

    hvt_decode #(.WIN_BASE(WIN_BASE), .WIN_REGS(WIN_REGS)) u_dec (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .win_hit  (win_hit),
        .exit_hit (exit_hit),
        .win_off  (win_off)
    );

    hvt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_hit   (win_hit),
        .exit_hit  (exit_hit),
        .cap_en    (cap_en),
        .sh_we     (sh_we),
        .entry_sel (entry_sel),
        .ctx_load  (ctx_load),
        .hv_mode   (hv_mode)
    );

    always_comb begin
        cap_bytes           = '0;
        cap_bytes[SH_A]     = a_in;
        cap_bytes[SH_X]     = x_in;
        cap_bytes[SH_Y]     = y_in;
        cap_bytes[SH_Z]     = z_in;
        cap_bytes[SH_FLAGS] = flags_in;
        cap_bytes[SH_SP]    = sp_in;
        cap_bytes[SH_PCL]   = pc_in[DW-1:0];
        cap_bytes[SH_PCH]   = pc_in[AW-1:DW];
        cap_bytes[SH_CFG]   = cfg_in;
    end

    hvt_shadow #(.N(SH_COUNT), .SEL_W(OFF_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_bytes (cap_bytes),
        .wr_en     (sh_we),
        .wr_sel    (win_off),
        .wr_data   (bus_wdata),
        .sh_bytes  (sh_bytes)
    );

    // Entry vector is latched with the trap so the offset need not persist
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vec_q <= VEC_BASE;
        else if (cap_en) vec_q <= VEC_BASE + AW'(win_off) * AW'(VEC_STRIDE);
    end

    if (X_DOUBLE) begin : g_xdbl
        assign x_entry = {1'b0, sh_bytes[SH_X][DW-3:0], 1'b0};
    end else begin : g_xplain
        assign x_entry = sh_bytes[SH_X];
    end

    always_comb begin
        pc_load   = ctx_load;
        pc_out    = {sh_bytes[SH_PCH], sh_bytes[SH_PCL]};
        a_out     = sh_bytes[SH_A];
        x_out     = sh_bytes[SH_X];
        y_out     = sh_bytes[SH_Y];
        z_out     = sh_bytes[SH_Z];
        flags_out = sh_bytes[SH_FLAGS];
        sp_out    = sh_bytes[SH_SP];
        cfg_out   = sh_bytes[SH_CFG];
        if (entry_sel) begin
            pc_out  = vec_q;
            x_out   = x_entry;
            cfg_out = HV_CFG;
        end
    end
endmodule

// File: rtl/hvt_ctrl_chk.sv
module hvt_ctrl_chk
    import hvt_pkg::*;
#(
    parameter logic [AW-1:0] WIN_BASE   = 16'hD640,
    parameter int            WIN_REGS   = 64,
    parameter logic [AW-1:0] VEC_BASE   = 16'h8000,
    parameter int            VEC_STRIDE = 4,
    parameter logic [DW-1:0] HV_CFG     = 8'hF0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] a_in,
    input logic          hv_mode,
    input logic          ctx_load,
    input logic [AW-1:0] pc_out,
    input logic [DW-1:0] a_out,
    input logic [DW-1:0] cfg_out
);
    logic [AW-1:0] rel;
    logic          in_win, user_trap, hyp_exit;

    always_comb begin
        rel       = bus_addr - WIN_BASE;
        in_win    = rel < AW'(WIN_REGS);
        user_trap = !hv_mode && !ctx_load && bus_we && in_win;
        hyp_exit  = hv_mode && !ctx_load && bus_we && (rel == AW'(WIN_REGS - 1));
    end

    // R2
    trap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_trap |=> (ctx_load && hv_mode));

    // R3
    entry_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_trap |=> (pc_out == AW'(VEC_BASE + AW'(VEC_STRIDE) * $past(rel))));

    // R4
    entry_a_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_trap |=> (a_out == $past(a_in)));

    // R6
    entry_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_load && hv_mode) |-> (cfg_out == HV_CFG));

    // R7
    exit_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hyp_exit |=> (ctx_load && !hv_mode));

    // R10
    exit_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_load && !hv_mode) |=> (!hv_mode && !ctx_load));

    // R11
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |=> !ctx_load);
endmodule

bind hvt_ctrl hvt_ctrl_chk #(
    .WIN_BASE(WIN_BASE), .WIN_REGS(WIN_REGS), .VEC_BASE(VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE), .HV_CFG(HV_CFG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .a_in(a_in), .hv_mode(hv_mode), .ctx_load(ctx_load),
    .pc_out(pc_out), .a_out(a_out), .cfg_out(cfg_out)
);

// File: tb/hvt_ctrl_tb.sv
module hvt_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'hD640;
    localparam logic [15:0] EXIT = 16'hD67F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  a_in = '0, x_in = '0, y_in = '0, z_in = '0;
    logic [7:0]  flags_in = '0, sp_in = '0, cfg_in = '0;
    logic        hv_mode, ctx_load, pc_load;
    logic [15:0] pc_out;
    logic [7:0]  a_out, x_out, y_out, z_out, flags_out, sp_out, cfg_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hvt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pc_in(pc_in), .a_in(a_in), .x_in(x_in),
        .y_in(y_in), .z_in(z_in), .flags_in(flags_in), .sp_in(sp_in),
        .cfg_in(cfg_in), .hv_mode(hv_mode), .ctx_load(ctx_load),
        .pc_load(pc_load), .pc_out(pc_out), .a_out(a_out), .x_out(x_out),
        .y_out(y_out), .z_out(z_out), .flags_out(flags_out),
        .sp_out(sp_out), .cfg_out(cfg_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] ad, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ad; bus_wdata = d;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0;
        @(posedge clk); #1;
    endtask

    // expected caller context
    logic [15:0] e_pc;
    logic [7:0]  e_a, e_x, e_y, e_z, e_f, e_sp, e_cfg;

    task automatic check_exit(input int k);
        check($sformatf("R7 load k=%0d", k), {30'd0, ctx_load, pc_load}, 32'h3);
        check($sformatf("R7 hv_mode k=%0d", k), hv_mode, 0);
        check($sformatf("R8 pc k=%0d", k), pc_out, e_pc);
        check($sformatf("R8 a k=%0d", k), a_out, e_a);
        check($sformatf("R8 x k=%0d", k), x_out, e_x);
        check($sformatf("R8 y/z k=%0d", k), {y_out, z_out}, {e_y, e_z});
        check($sformatf("R8 flags/sp k=%0d", k), {flags_out, sp_out}, {e_f, e_sp});
        check($sformatf("R8 cfg k=%0d", k), cfg_out, e_cfg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 hv_mode", hv_mode, 0);
        check("R1 loads", {ctx_load, pc_load}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 addresses just outside the window do nothing in user mode
        wr(16'hD63F, 8'h11); check("R2 below window", {hv_mode, ctx_load}, 0);
        idle();
        wr(16'hD680, 8'h22); check("R2 above window", {hv_mode, ctx_load}, 0);
        idle();

        for (int k = 0; k < 64; k++) begin
            pc_in    = 16'h1000 + 16'(k * 37);
            a_in     = 8'(k) ^ 8'h5A;
            x_in     = 8'(k * 5 + 8'hC3);
            y_in     = 8'(k * 7);
            z_in     = 8'(k * 11 + 3);
            flags_in = 8'(k * 13) & 8'hFE;
            sp_in    = ~8'(k);
            cfg_in   = 8'(k + 1);
            e_pc = pc_in; e_a = a_in; e_x = x_in; e_y = y_in; e_z = z_in;
            e_f = flags_in; e_sp = sp_in; e_cfg = cfg_in;

            wr(BASE + 16'(k), 8'hEE ^ 8'(k));
            check($sformatf("R2 entry load k=%0d", k), {29'd0, ctx_load, pc_load, hv_mode}, 32'h7);
            check($sformatf("R3 vector k=%0d", k), pc_out, 16'h8000 + 16'(4 * k));
            check($sformatf("R4 a/y/z k=%0d", k), {a_out, y_out, z_out}, {e_a, e_y, e_z});
            check($sformatf("R4 flags/sp k=%0d", k), {flags_out, sp_out}, {e_f, e_sp});
            check($sformatf("R5 x k=%0d", k), x_out, {1'b0, e_x[5:0], 1'b0});
            check($sformatf("R6 cfg k=%0d", k), cfg_out, 8'hF0);

            if (k == 10) begin
                // R10 exit write held into the ENTER cycle is ignored
                wr(EXIT, 8'h00);
                check("R10 enter collision", {hv_mode, ctx_load}, 2'b10);
            end
            idle();
            check($sformatf("R11 pulse k=%0d", k), {hv_mode, ctx_load, pc_load}, 3'b100);

            // caller inputs change; exit must use shadow values
            pc_in = ~pc_in; a_in = ~a_in; x_in = ~x_in; cfg_in = ~cfg_in;

            case (k % 4)
                0: begin
                    wr(BASE + 16'd0, 8'(k) ^ 8'hA5); e_a = 8'(k) ^ 8'hA5; idle();
                    wr(BASE + 16'd4, e_f | 8'h01);   e_f = e_f | 8'h01;   idle();
                    wr(BASE + 16'd6, 8'h34);         e_pc[7:0] = 8'h34;   idle();
                    wr(BASE + 16'd7, 8'(k) + 8'h20); e_pc[15:8] = 8'(k) + 8'h20; idle();
                    wr(BASE + 16'd8, 8'h3C);         e_cfg = 8'h3C;       idle();
                    check($sformatf("R8 no load k=%0d", k), {hv_mode, ctx_load}, 2'b10);
                end
                1: begin
                    wr(BASE + 16'(9 + (k % 54)), 8'hFF);
                    idle();
                    check($sformatf("R9 hyper retrap k=%0d", k), {hv_mode, ctx_load}, 2'b10);
                    wr(16'hD63F, 8'hFF); idle();
                    wr(16'hD680, 8'hFF); idle();
                    check($sformatf("R9 outside k=%0d", k), {hv_mode, ctx_load}, 2'b10);
                end
                2: begin
                    wr(BASE + 16'd1, 8'(k) + 8'h80); e_x = 8'(k) + 8'h80; idle();
                    wr(BASE + 16'd2, 8'h99); e_y = 8'h99; idle();
                    wr(BASE + 16'd3, 8'h66); e_z = 8'h66; idle();
                    wr(BASE + 16'd5, 8'h42); e_sp = 8'h42; idle();
                end
                default: ;
            endcase

            wr(EXIT, 8'h00);
            check_exit(k);
            if (k % 8 == 5) begin
                // R10 trap write held into the EXIT cycle is ignored
                wr(BASE + 16'd3, 8'h00);
                check($sformatf("R10 exit collision k=%0d", k), {hv_mode, ctx_load}, 0);
                idle();
            end else begin
                idle();
            end
            check($sformatf("R11 after exit k=%0d", k), {hv_mode, ctx_load, pc_load}, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule